// File: doc/BRIEF.md
# I2C Target Receive Engine with Clock Stretching

This block is the receive side of an I2C target. It runs on a system clock much faster than the bus. It watches the bus lines through synchronizers, detects START, repeated START and STOP, and compares each address byte with a 7-bit own address. It can also accept the general call address. Once addressed for a write, it acknowledges the address and each data byte, and collects bytes MSB first. It stretches the bus clock by pulling SCL low while software has not yet handled the previous event. The block never drives either line high. Its two outputs only request that a line be pulled low.

Software sees a small register-style interface:
- three interrupt flags (address matched, STOP seen, byte finished), each cleared by writing 1;
- a receive-buffer-full status and a receive data port, where a read strobe consumes the byte;
- a direction flag;
- a control word that holds a one-shot NACK request and the general call enable.

A matched address also gives a one-cycle wake request, so a sleeping system can be woken by the address event. When a read-direction address matches, the block only reports it. It does not acknowledge it and does not stretch the clock.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset, both line-drive outputs are 0, all flags, the NACK request, the general call enable and the receive data are 0.
- R2: An address byte equal to {own_addr, 0} sets the START flag (flag word bit 0), clears the direction flag, gives a one-cycle wake_req pulse and pulls SDA low for the ninth clock.
- R3: After an own-address write byte, SCL is held low from the eighth falling edge until the START flag is cleared.
- R4: A data byte is shifted in MSB first. After its eighth falling edge, rxd_q holds the byte, rx_full and the byte-end flag (bit 2) are set, and SCL is held low.
- R5: A rxd_re strobe clears rx_full and releases SCL, and the byte is then acknowledged with SDA low.
- R6: If the NACK request (control bit 0) is 1 when a byte finishes, that byte is answered with SDA released. The request returns to 0 after that acknowledge clock. Further bytes are ignored until the next START or STOP.
- R7: The general call address byte 0x00 is acknowledged only while the general call enable (control bit 1) is 1.
- R8: An address byte that does not match produces no acknowledge, no flag, no stretching and no wake request. Following bytes and the STOP are ignored.
- R9: A STOP after a matched address sets the STOP flag (bit 1). A repeated START returns the block to the address phase without setting the STOP flag.
- R10: An own-address byte with the read bit set sets the START flag and the direction flag, with no acknowledge and no stretching.
- R11: A flag-word write clears each flag whose data bit is 1 (bit 0 START, bit 1 STOP, bit 2 byte-end) and leaves flags with data bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low when 1 (acknowledge) |
| own_addr | input | 7 | Own target address |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Bit 0 NACK request, bit 1 general call enable |
| intf_we | input | 1 | Flag word write strobe (write 1 to clear) |
| intf_wdata | input | 3 | Bit 0 START, bit 1 STOP, bit 2 byte-end |
| rxd_re | input | 1 | Receive data read strobe |
| rxd_q | output | 8 | Receive data register |
| irq_start | output | 1 | Address matched flag |
| irq_stop | output | 1 | STOP after match flag |
| irq_byte_end | output | 1 | Byte finished flag |
| rx_full | output | 1 | Receive buffer full |
| dir_read | output | 1 | Direction of the last matched address (1 = read) |
| nack_req_q | output | 1 | Pending NACK request |
| gc_en_q | output | 1 | General call enable |
| wake_req | output | 1 | One-cycle pulse on address match |

## Verification
The bench uses the default two-stage synchronizer. It plays an open-drain bus master whose quarter bit period is ten system clocks, which is wide enough for the synchronizer and edge-detector latency to settle before each check. With own_addr fixed at 0x52, both directions, a foreign address and the general call address can be reached in short transfers. The master raises SCL and holds it there during every acknowledge clock, so each stretch is seen as a line that stays low until software acts.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam int FLG_START = 0;
  localparam int FLG_STOP  = 1;
  localparam int FLG_BEND  = 2;
  localparam int FLG_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HOLD,
    ST_ACK
  } eng_state_e;

  // Address byte hits own address (either direction) or general call (write only).
  function automatic logic addr_hit(input logic [BYTE_W-1:0] abyte,
                                    input logic [ADDR_W-1:0] own,
                                    input logic gc_en);
    return (abyte[BYTE_W-1:1] == own) || (gc_en && (abyte == '0));
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s && !scl_d;
  assign scl_fall  = !scl_s &&  scl_d;
  assign start_det =  scl_s && scl_d && !sda_s &&  sda_d;
  assign stop_det  =  scl_s && scl_d &&  sda_s && !sda_d;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              nack_req,
  input  logic              start_pend,
  input  logic              buf_full,
  output logic              scl_low,
  output logic              sda_low,
  output logic              ev_match,
  output logic              ev_dir,
  output logic              ev_byte,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ev_nack_done,
  output logic              ev_stop,
  output logic              in_hold,
  output logic              hold_addr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  eng_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;
  logic              hold_is_addr, nack_q, addressed;
  logic              quiet, byte_done, shifting, release_ok;

  assign quiet     = !start_det && !stop_det;
  assign shifting  = (state == ST_ADDR) || (state == ST_DATA);
  assign byte_done = shifting && scl_fall && (cnt == FULL) && quiet;

  assign ev_match     = byte_done && (state == ST_ADDR) && addr_hit(sr, own_addr, gc_en);
  assign ev_dir       = sr[0];
  assign ev_byte      = byte_done && (state == ST_DATA);
  assign byte_val     = sr;
  assign ev_nack_done = (state == ST_ACK) && scl_fall && nack_q && quiet;
  assign ev_stop      = stop_det && !start_det && addressed;

  assign in_hold    = (state == ST_HOLD);
  assign hold_addr  = in_hold && hold_is_addr;
  assign release_ok = hold_is_addr ? !start_pend : !buf_full;

  assign scl_low = in_hold;
  assign sda_low = (in_hold || (state == ST_ACK)) && !nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      sr           <= '0;
      hold_is_addr <= 1'b0;
      nack_q       <= 1'b0;
      addressed    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      cnt       <= '0;
      nack_q    <= 1'b0;
      addressed <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      nack_q    <= 1'b0;
      addressed <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && (cnt != FULL)) begin
            sr  <= {sr[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (ev_match) begin
                addressed    <= 1'b1;
                hold_is_addr <= 1'b1;
                nack_q       <= 1'b0;
                state        <= sr[0] ? ST_IDLE : ST_HOLD;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              hold_is_addr <= 1'b0;
              nack_q       <= nack_req;
              state        <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (release_ok) state <= ST_ACK;
        ST_ACK: begin
          if (scl_fall) begin
            cnt   <= '0;
            state <= nack_q ? ST_IDLE : ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              intf_we,
  input  logic [FLG_W-1:0]  intf_wdata,
  input  logic              rxd_re,
  output logic [BYTE_W-1:0] rxd_q,
  output logic              irq_start,
  output logic              irq_stop,
  output logic              irq_byte_end,
  output logic              rx_full,
  output logic              dir_read,
  output logic              nack_req_q,
  output logic              gc_en_q,
  output logic              wake_req
);
  logic [1:0]        lines_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              ev_match, ev_dir, ev_byte, ev_nack_done, ev_stop;
  logic              in_hold, hold_addr;
  logic [BYTE_W-1:0] byte_val;
  logic              clr_start, clr_stop, clr_bend;

  i2c_tgt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(lines_s)
  );

  i2c_tgt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(lines_s[0]),
    .own_addr(own_addr), .gc_en(gc_en_q), .nack_req(nack_req_q),
    .start_pend(irq_start), .buf_full(rx_full),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .ev_match(ev_match), .ev_dir(ev_dir), .ev_byte(ev_byte),
    .byte_val(byte_val), .ev_nack_done(ev_nack_done), .ev_stop(ev_stop),
    .in_hold(in_hold), .hold_addr(hold_addr)
  );

  assign clr_start = intf_we && intf_wdata[FLG_START];
  assign clr_stop  = intf_we && intf_wdata[FLG_STOP];
  assign clr_bend  = intf_we && intf_wdata[FLG_BEND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_start    <= 1'b0;
      irq_stop     <= 1'b0;
      irq_byte_end <= 1'b0;
      rx_full      <= 1'b0;
      rxd_q        <= '0;
      dir_read     <= 1'b0;
      nack_req_q   <= 1'b0;
      gc_en_q      <= 1'b0;
      wake_req     <= 1'b0;
    end else begin
      wake_req <= ev_match;
      if (ev_match)       irq_start <= 1'b1;
      else if (clr_start) irq_start <= 1'b0;
      if (ev_stop)        irq_stop <= 1'b1;
      else if (clr_stop)  irq_stop <= 1'b0;
      if (ev_byte)        irq_byte_end <= 1'b1;
      else if (clr_bend)  irq_byte_end <= 1'b0;
      if (ev_byte) begin
        rx_full <= 1'b1;
        rxd_q   <= byte_val;
      end else if (rxd_re) begin
        rx_full <= 1'b0;
      end
      if (ev_match) dir_read <= ev_dir;
      if (ctl_we) begin
        nack_req_q <= ctl_wdata[0];
        gc_en_q    <= ctl_wdata[1];
      end else if (ev_nack_done) begin
        nack_req_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_match,
  input logic ev_byte,
  input logic ev_nack_done,
  input logic in_hold,
  input logic hold_addr,
  input logic irq_start,
  input logic irq_byte_end,
  input logic rx_full,
  input logic rxd_re,
  input logic ctl_we,
  input logic nack_req_q,
  input logic intf_we,
  input logic intf_start_bit,
  input logic scl_drive_low,
  input logic wake_req
);
  p_wake_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  p_addr_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_addr && irq_start) |-> scl_drive_low);

  p_byte_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> (rx_full && irq_byte_end));

  p_data_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !hold_addr && rx_full) |-> scl_drive_low);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_re && !ev_byte) |=> !rx_full);

  p_nack_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack_done && !ctl_we) |=> !nack_req_q);

  p_w1c_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (intf_we && intf_start_bit && !ev_match) |=> !irq_start);
endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_match(ev_match), .ev_byte(ev_byte),
  .ev_nack_done(ev_nack_done), .in_hold(in_hold), .hold_addr(hold_addr),
  .irq_start(irq_start), .irq_byte_end(irq_byte_end), .rx_full(rx_full),
  .rxd_re(rxd_re), .ctl_we(ctl_we), .nack_req_q(nack_req_q),
  .intf_we(intf_we), .intf_start_bit(intf_wdata[0]),
  .scl_drive_low(scl_drive_low), .wake_req(wake_req)
);

// File: tb/sim_i2c_tgt_rx.sv
module sim_i2c_tgt_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_drive_low, sda_drive_low;
  logic ctl_we = 1'b0, intf_we = 1'b0, rxd_re = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic [2:0] intf_wdata = '0;
  logic [7:0] rxd_q;
  logic irq_start, irq_stop, irq_byte_end, rx_full, dir_read, nack_req_q, gc_en_q, wake_req;
  logic scl_line, sda_line;
  int n_chk = 0, n_fail = 0, wake_cnt = 0;
  bit done = 1'b0;

  assign scl_line = m_scl & ~scl_drive_low;
  assign sda_line = m_sda & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(OWN), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .intf_we(intf_we), .intf_wdata(intf_wdata), .rxd_re(rxd_re), .rxd_q(rxd_q),
    .irq_start(irq_start), .irq_stop(irq_stop), .irq_byte_end(irq_byte_end),
    .rx_full(rx_full), .dir_read(dir_read), .nack_req_q(nack_req_q),
    .gc_en_q(gc_en_q), .wake_req(wake_req)
  );

  always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic m_restart();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic m_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask
  task automatic m_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    end
  endtask
  // Raise SCL for the acknowledge clock and report whether the line is held low.
  task automatic m_ack_try(output logic held);
    m_sda = 1'b1; m_scl = 1'b1;
    repeat (30) @(negedge clk);
    held = ~scl_line;
  endtask
  task automatic m_ack_end(output logic ack);
    while (!scl_line) @(negedge clk);
    qw(); ack = ~sda_line; m_scl = 1'b0; qw();
  endtask

  task automatic sw_ctl(input logic [1:0] d);
    ctl_we = 1'b1; ctl_wdata = d; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic sw_clr(input logic [2:0] m);
    intf_we = 1'b1; intf_wdata = m; @(negedge clk); intf_we = 1'b0;
  endtask
  task automatic sw_read(output logic [7:0] d);
    rxd_re = 1'b1; d = rxd_q; @(negedge clk); rxd_re = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 scl drive", scl_drive_low, 0);
    chk("R1 sda drive", sda_drive_low, 0);
    chk("R1 flags", {irq_start, irq_stop, irq_byte_end, rx_full, dir_read, nack_req_q, gc_en_q}, 0);
    chk("R1 rxd", rxd_q, 0);
  endtask

  task automatic t_write_nack();
    logic held, ack; logic [7:0] d;
    m_start(); m_bits({OWN, 1'b0});
    chk("R2 start flag", irq_start, 1);
    chk("R2 dir write", dir_read, 0);
    chk("R2 wake pulse", wake_cnt, 1);
    m_ack_try(held);
    chk("R3 addr stretch", held, 1);
    chk("R2 ack driven", sda_drive_low, 1);
    sw_clr(3'b000);
    chk("R11 zero keeps start", irq_start, 1);
    repeat (5) @(negedge clk);
    chk("R3 still held", scl_line, 0);
    sw_clr(3'b001);
    chk("R11 start cleared", irq_start, 0);
    m_ack_end(ack);
    chk("R2 addr ack", ack, 1);
    m_bits(8'hA5);
    chk("R4 rxd", rxd_q, 8'hA5);
    chk("R4 full+bend", {rx_full, irq_byte_end}, 2'b11);
    m_ack_try(held);
    chk("R4 data stretch", held, 1);
    sw_clr(3'b100);
    chk("R11 bend cleared", irq_byte_end, 0);
    repeat (5) @(negedge clk);
    chk("R5 held until read", scl_line, 0);
    sw_read(d);
    chk("R5 read data", d, 8'hA5);
    chk("R5 full cleared", rx_full, 0);
    m_ack_end(ack);
    chk("R5 data ack", ack, 1);
    sw_ctl(2'b01);
    chk("R6 nack req set", nack_req_q, 1);
    m_bits(8'h3C);
    chk("R4 second byte", rxd_q, 8'h3C);
    m_ack_try(held);
    sw_read(d);
    sw_clr(3'b100);
    m_ack_end(ack);
    chk("R6 nack sent", ack, 0);
    chk("R6 req self clear", nack_req_q, 0);
    m_bits(8'h77);
    chk("R6 ignored full", rx_full, 0);
    chk("R6 ignored data", rxd_q, 8'h3C);
    m_ack_try(held);
    chk("R6 no stretch", held, 0);
    m_ack_end(ack);
    chk("R6 no ack", ack, 0);
    m_stop();
    chk("R9 stop flag", irq_stop, 1);
    sw_clr(3'b010);
    chk("R11 stop cleared", irq_stop, 0);
  endtask

  task automatic t_mismatch();
    logic held, ack; int w0;
    w0 = wake_cnt;
    m_start(); m_bits(8'h20);
    chk("R8 no start flag", irq_start, 0);
    m_ack_try(held);
    chk("R8 no stretch", held, 0);
    m_ack_end(ack);
    chk("R8 no ack", ack, 0);
    m_bits(8'h11);
    m_ack_try(held); m_ack_end(ack);
    chk("R8 byte ignored", {rx_full, irq_byte_end, ack}, 0);
    m_stop();
    chk("R8 no stop flag", irq_stop, 0);
    chk("R8 no wake", wake_cnt, w0);
  endtask

  task automatic t_gcall();
    logic held, ack; logic [7:0] d;
    m_start(); m_bits(8'h00);
    chk("R7 gc disabled", irq_start, 0);
    m_ack_try(held); m_ack_end(ack);
    chk("R7 gc disabled ack", ack, 0);
    m_stop();
    sw_ctl(2'b10);
    chk("R7 gc enable", gc_en_q, 1);
    m_start(); m_bits(8'h00);
    chk("R7 gc match", irq_start, 1);
    m_ack_try(held);
    sw_clr(3'b001);
    m_ack_end(ack);
    chk("R7 gc ack", ack, 1);
    m_bits(8'h5A);
    m_ack_try(held);
    sw_read(d);
    chk("R7 gc data", d, 8'h5A);
    m_ack_end(ack);
    m_stop();
    sw_clr(3'b111);
    sw_ctl(2'b00);
  endtask

  task automatic t_restart_read();
    logic held, ack; logic [7:0] d;
    m_start(); m_bits({OWN, 1'b0});
    m_ack_try(held); sw_clr(3'b001); m_ack_end(ack);
    m_bits(8'h99);
    m_ack_try(held); sw_read(d); m_ack_end(ack);
    chk("R4 byte before restart", d, 8'h99);
    m_restart(); m_bits({OWN, 1'b1});
    chk("R10 start flag", irq_start, 1);
    chk("R10 dir read", dir_read, 1);
    chk("R9 restart no stop", irq_stop, 0);
    m_ack_try(held);
    chk("R10 no stretch", held, 0);
    m_ack_end(ack);
    chk("R10 no ack", ack, 0);
    m_stop();
    chk("R9 stop after read match", irq_stop, 1);
    sw_clr(3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_nack();
    t_mismatch();
    t_gcall();
    t_restart_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule